// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a processor's fetch logic. It decides whether an incoming interrupt is taken and, once one is taken, it performs the whole exception entry on its own. An interrupt request carries a 16-bit vector. Only the low byte of that vector matters: its upper nibble is a priority level and its lower nibble is a number. The block checks that byte against the enable bit and the level field of the current system status word. A synchronous trap request may arrive instead; it supplies the vector-table address directly. Accepted requests are held in pending latches until the sequencer is free, so a request is not lost while a sequence is in progress.

Each entry sequence runs as five single-word accesses on a 32-bit valid/ready memory bus. First it writes three words to the supervisor stack: the return program counter, the program status word and the system status word. These three words go to a non-monotonic set of slots. Then it reads the new system status word and the new program counter from the vector-table entry. The previous-mode bit of the loaded status word is replaced with the user-mode bit that was active before entry. The supervisor stack pointer drops by twice the frame size. A one-cycle done pulse then hands the new program counter, the new status word and the new stack pointer to the processor. On that pulse the processor also clears its program status word.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and after it falls, bus_valid and done are low until an interrupt or trap has been latched.
- R2: Only irq_vec[7:0] is used; bits 15:8 have no effect. The table entry for an interrupt is 0x800 + 8 × irq_vec[7:0].
- R3: A vector byte of 0x00 is accepted whatever the enable bit and level are.
- R4: Any other byte is accepted only when cur_ssw[4] (enable) is 1 and irq_vec[7:4] ≤ cur_ssw[3:0] (level). Otherwise it is dropped, and no bus access follows.
- R5: A sequence begins with three writes in this order: cur_pc to ssp−4, then cur_psw to ssp−12, then cur_ssw to ssp−8.
- R6: After the writes the sequence makes two reads: the table entry address, then that address + 4.
- R7: new_ssw is the word read from the entry address, with bit 9 (previous mode) replaced by cur_ssw[8] (user mode) as it was when the sequence started.
- R8: done is high for exactly one cycle per sequence. While done is high, new_pc equals the word read from entry + 4 and new_ssp equals ssp − 24.
- R9: bus_valid stays high, and bus_addr, bus_write and bus_wdata stay stable, until bus_ready completes the access. Wait states only stretch the sequence.
- R10: trap_req latches trap_addr, which is used as the table entry address. When a trap and an interrupt are both pending, the trap sequence runs first and the interrupt sequence follows.
- R11: An interrupt accepted while a sequence runs, or in the same cycle its pending latch is drained, is kept and serviced by the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 16 | Interrupt vector; low byte is level and number |
| cur_ssw | input | 32 | Current system status word |
| cur_psw | input | 32 | Current program status word |
| ssp | input | 32 | Supervisor stack pointer |
| cur_pc | input | 32 | Return program counter |
| trap_req | input | 1 | Trap request strobe |
| trap_addr | input | 32 | Vector-table entry address of the trap |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Program counter to resume at |
| new_ssw | output | 32 | System status word to install |
| new_ssp | output | 32 | Supervisor stack pointer to install |

## Verification
Two functions can fall in the same cycle: the sequencer draining the interrupt latch as it starts a sequence, and the acceptance of a fresh interrupt that sets the same latch. The bench pulses an interrupt in one cycle and a second one in the next cycle, which is exactly the clock edge at which the first is taken. It then expects two full sequences at the two table entries, in that order. A trap and a non-maskable interrupt raised together test the other collision, the choice between two pending sources. Here the first read must hit the trap address.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN     = 32;
  // system status word field positions
  localparam int LVL_LSB  = 0;
  localparam int LVL_W    = 4;
  localparam int EN_BIT   = 4;
  localparam int USER_BIT = 8;
  localparam int PREV_BIT = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUT_PC,
    ST_PUT_PSW,
    ST_PUT_SSW,
    ST_GET_SSW,
    ST_GET_PC
  } seq_state_t;

  typedef struct packed {
    logic [XLEN-1:0] sp;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] psw;
    logic [XLEN-1:0] ssw;
    logic [XLEN-1:0] entry;
  } frame_snap_t;
endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_pkg::*;
(
  input  logic             irq_req,
  input  logic [15:0]      irq_vec,
  input  logic             int_en,
  input  logic [LVL_W-1:0] cur_level,
  output logic             accept,
  output logic [7:0]       vec_byte
);
  logic [LVL_W-1:0] req_level;
  logic             non_maskable;
  logic             unused_vec_hi;

  assign unused_vec_hi = ^irq_vec[15:8];
  assign vec_byte      = irq_vec[7:0];
  assign req_level     = vec_byte[7:4];
  assign non_maskable  = (vec_byte == 8'h00);
  assign accept        = irq_req && (non_maskable || (int_en && (req_level <= cur_level)));
endmodule

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_accept,
  input  logic [7:0]      irq_byte,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_addr,
  input  logic            take_irq,
  input  logic            take_trap,
  output logic            irq_pend,
  output logic [7:0]      irq_byte_q,
  output logic            trap_pend,
  output logic [XLEN-1:0] trap_addr_q
);
  // a new request in the drain cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend    <= 1'b0;
      irq_byte_q  <= '0;
      trap_pend   <= 1'b0;
      trap_addr_q <= '0;
    end else begin
      if (irq_accept) begin
        irq_pend   <= 1'b1;
        irq_byte_q <= irq_byte;
      end else if (take_irq) begin
        irq_pend <= 1'b0;
      end
      if (trap_req) begin
        trap_pend   <= 1'b1;
        trap_addr_q <= trap_addr;
      end else if (take_trap) begin
        trap_pend <= 1'b0;
      end
    end
  end

  AST_IRQ_KEPT: assert property (@(posedge clk) disable iff (rst)
    irq_pend && !take_irq |=> irq_pend); // R11
  AST_TRAP_KEPT: assert property (@(posedge clk) disable iff (rst)
    trap_pend && !take_trap |=> trap_pend); // R10
endmodule

// File: rtl/exc_bus_fsm.sv
module exc_bus_fsm
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0800,
  parameter int              SLOT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_pend,
  input  logic [7:0]      irq_byte,
  input  logic            trap_pend,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [XLEN-1:0] cur_ssw,
  input  logic [XLEN-1:0] ssp,
  output logic            take_irq,
  output logic            take_trap,
  output logic            bus_valid,
  output logic            bus_write,
  output logic [XLEN-1:0] bus_addr,
  output logic [XLEN-1:0] bus_wdata,
  input  logic            bus_ready,
  input  logic [XLEN-1:0] bus_rdata,
  output logic            done,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_ssw,
  output logic [XLEN-1:0] new_ssp
);
  localparam logic [XLEN-1:0] SLOT      = XLEN'(SLOT_BYTES);
  localparam logic [XLEN-1:0] FRAME     = 3 * SLOT;
  localparam logic [XLEN-1:0] SP_DROP   = 2 * FRAME;
  localparam int              ENTRY_SHIFT = 3;

  seq_state_t       st;
  frame_snap_t      snap;
  logic             start;
  logic [XLEN-1:0]  entry_next;
  logic [XLEN-1:0]  ssw_loaded;

  assign start      = (st == ST_IDLE) && (trap_pend || irq_pend);
  assign take_trap  = start && trap_pend;
  assign take_irq   = start && !trap_pend;
  assign entry_next = trap_pend ? trap_addr
                                : VEC_BASE + (XLEN'(irq_byte) << ENTRY_SHIFT);

  always_comb begin
    ssw_loaded           = bus_rdata;
    ssw_loaded[PREV_BIT] = snap.ssw[USER_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      snap    <= '0;
      done    <= 1'b0;
      new_pc  <= '0;
      new_ssw <= '0;
      new_ssp <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          snap.sp    <= ssp;
          snap.pc    <= cur_pc;
          snap.psw   <= cur_psw;
          snap.ssw   <= cur_ssw;
          snap.entry <= entry_next;
          st         <= ST_PUT_PC;
        end
        ST_PUT_PC:  if (bus_ready) st <= ST_PUT_PSW;
        ST_PUT_PSW: if (bus_ready) st <= ST_PUT_SSW;
        ST_PUT_SSW: if (bus_ready) st <= ST_GET_SSW;
        ST_GET_SSW: if (bus_ready) begin
          new_ssw <= ssw_loaded;
          st      <= ST_GET_PC;
        end
        ST_GET_PC: if (bus_ready) begin
          new_pc  <= bus_rdata;
          new_ssp <= snap.sp - SP_DROP;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_valid = (st != ST_IDLE);
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      ST_PUT_PC:  begin bus_write = 1'b1; bus_addr = snap.sp - SLOT;      bus_wdata = snap.pc;  end
      ST_PUT_PSW: begin bus_write = 1'b1; bus_addr = snap.sp - FRAME;     bus_wdata = snap.psw; end
      ST_PUT_SSW: begin bus_write = 1'b1; bus_addr = snap.sp - 2 * SLOT;  bus_wdata = snap.ssw; end
      ST_GET_SSW: bus_addr = snap.entry;
      ST_GET_PC:  bus_addr = snap.entry + SLOT;
      default: ;
    endcase
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE   = 32'h0000_0800,
  parameter int          SLOT_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        irq_req,
  input  logic [15:0] irq_vec,
  input  logic [31:0] cur_ssw,
  input  logic [31:0] cur_psw,
  input  logic [31:0] ssp,
  input  logic [31:0] cur_pc,
  input  logic        trap_req,
  input  logic [31:0] trap_addr,
  output logic        bus_valid,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ready,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic [31:0] new_pc,
  output logic [31:0] new_ssw,
  output logic [31:0] new_ssp
);
  logic            irq_accept;
  logic [7:0]      irq_byte;
  logic            irq_pend;
  logic [7:0]      irq_byte_q;
  logic            trap_pend;
  logic [XLEN-1:0] trap_addr_q;
  logic            take_irq;
  logic            take_trap;

  exc_accept u_accept (
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .int_en    (cur_ssw[EN_BIT]),
    .cur_level (cur_ssw[LVL_LSB +: LVL_W]),
    .accept    (irq_accept),
    .vec_byte  (irq_byte)
  );

  exc_pending u_pend (
    .clk         (clk),
    .rst         (rst),
    .irq_accept  (irq_accept),
    .irq_byte    (irq_byte),
    .trap_req    (trap_req),
    .trap_addr   (trap_addr),
    .take_irq    (take_irq),
    .take_trap   (take_trap),
    .irq_pend    (irq_pend),
    .irq_byte_q  (irq_byte_q),
    .trap_pend   (trap_pend),
    .trap_addr_q (trap_addr_q)
  );

  exc_bus_fsm #(
    .VEC_BASE   (VEC_BASE),
    .SLOT_BYTES (SLOT_BYTES)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .irq_pend  (irq_pend),
    .irq_byte  (irq_byte_q),
    .trap_pend (trap_pend),
    .trap_addr (trap_addr_q),
    .cur_pc    (cur_pc),
    .cur_psw   (cur_psw),
    .cur_ssw   (cur_ssw),
    .ssp       (ssp),
    .take_irq  (take_irq),
    .take_trap (take_trap),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .done      (done),
    .new_pc    (new_pc),
    .new_ssw   (new_ssw),
    .new_ssp   (new_ssp)
  );

  AST_NMI_LATCHED: assert property (@(posedge clk) disable iff (rst)
    irq_req && (irq_vec[7:0] == 8'h00) |=> irq_pend); // R3
  AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (rst)
    irq_req && (irq_vec[7:0] != 8'h00) && !cur_ssw[EN_BIT] && !irq_pend |=> !irq_pend); // R4
  AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !bus_valid && !irq_pend && !trap_pend |=> !bus_valid); // R1
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic [15:0] irq_vec = '0;
  logic [31:0] cur_ssw = '0;
  logic [31:0] cur_psw = '0;
  logic [31:0] ssp = '0;
  logic [31:0] cur_pc = '0;
  logic        trap_req = 1'b0;
  logic [31:0] trap_addr = '0;
  logic        bus_valid, bus_write, done;
  logic [31:0] bus_addr, bus_wdata, new_pc, new_ssw, new_ssp;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [logic [31:0]];
  logic        lg_we   [16];
  logic [31:0] lg_addr [16];
  logic [31:0] lg_data [16];
  int          lg_n = 0;
  int          wait_n = 0;
  int          wait_cnt = 0;
  int          hold_err = 0;
  logic [31:0] held_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
    .cur_ssw(cur_ssw), .cur_psw(cur_psw), .ssp(ssp), .cur_pc(cur_pc),
    .trap_req(trap_req), .trap_addr(trap_addr),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .done(done), .new_pc(new_pc), .new_ssw(new_ssw), .new_ssp(new_ssp)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'hDEAD_0000 ^ a;
  endfunction

  // bus responder: decides ready at the falling edge, logs completed accesses
  initial begin
    forever begin
      @(negedge clk);
      if (bus_valid) begin
        if (wait_cnt == 0) held_addr = bus_addr;
        else if (bus_addr !== held_addr) hold_err++;
        if (wait_cnt < wait_n) begin
          wait_cnt++;
          bus_ready = 1'b0;
        end else begin
          bus_ready = 1'b1;
          bus_rdata = bus_write ? 32'h0 : mem_rd(bus_addr);
          if (lg_n < 16) begin
            lg_we[lg_n]   = bus_write;
            lg_addr[lg_n] = bus_addr;
            lg_data[lg_n] = bus_write ? bus_wdata : bus_rdata;
            lg_n++;
          end
          wait_cnt = 0;
        end
      end else begin
        bus_ready = 1'b0;
        wait_cnt  = 0;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_irq(input logic [15:0] v);
    @(negedge clk); irq_req = 1'b1; irq_vec = v;
    @(negedge clk); irq_req = 1'b0;
  endtask

  // waits for done, checks the five accesses at log position base and the results
  task automatic expect_seq(input int base, input logic [31:0] entry, input logic [31:0] exp_pc,
                            input logic [31:0] mem_ssw, input string tag);
    int   n = 0;
    logic [31:0] exp_ssw;
    while (!done && n < 300) begin @(negedge clk); n++; end
    check(done === 1'b1, {tag, " R8 done seen"}, 64'(done), 64'd1);
    exp_ssw = (mem_ssw & ~32'h200) | (32'(cur_ssw[8]) << 9);
    check({lg_we[base], lg_addr[base], lg_data[base]} === {1'b1, ssp - 32'd4, cur_pc},
          {tag, " R5 slot pc"}, 64'(lg_addr[base]), 64'(ssp - 32'd4));
    check({lg_we[base+1], lg_addr[base+1], lg_data[base+1]} === {1'b1, ssp - 32'd12, cur_psw},
          {tag, " R5 slot psw"}, 64'(lg_addr[base+1]), 64'(ssp - 32'd12));
    check({lg_we[base+2], lg_addr[base+2], lg_data[base+2]} === {1'b1, ssp - 32'd8, cur_ssw},
          {tag, " R5 slot ssw"}, 64'(lg_addr[base+2]), 64'(ssp - 32'd8));
    check({lg_we[base+3], lg_addr[base+3]} === {1'b0, entry},
          {tag, " R6 read ssw"}, 64'(lg_addr[base+3]), 64'(entry));
    check({lg_we[base+4], lg_addr[base+4]} === {1'b0, entry + 32'd4},
          {tag, " R6 read pc"}, 64'(lg_addr[base+4]), 64'(entry + 32'd4));
    check(new_pc === exp_pc, {tag, " R8 new_pc"}, 64'(new_pc), 64'(exp_pc));
    check(new_ssp === ssp - 32'd24, {tag, " R8 new_ssp"}, 64'(new_ssp), 64'(ssp - 32'd24));
    check(new_ssw === exp_ssw, {tag, " R7 new_ssw"}, 64'(new_ssw), 64'(exp_ssw));
    @(negedge clk);
    check(done === 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    check(bus_valid === 1'b0 && done === 1'b0, "R1 in reset", 64'({bus_valid, done}), 64'd0);
    @(negedge clk); rst = 1'b0;
    settle(4);
    check(bus_valid === 1'b0 && done === 1'b0 && lg_n == 0, "R1 after reset",
          64'({bus_valid, done}), 64'd0);
  endtask

  task automatic t_nmi_masked_state;
    lg_n = 0;
    cur_ssw = 32'h0000_0100; // disabled, user mode, level 0
    mem[32'h800] = 32'h0000_0210;
    mem[32'h804] = 32'h1234_5670;
    pulse_irq(16'hAB00);
    expect_seq(0, 32'h800, 32'h1234_5670, 32'h0000_0210, "nmi R3 R2");
  endtask

  task automatic t_masked;
    lg_n = 0;
    cur_ssw = 32'h0000_0003;           // disabled, level 3
    pulse_irq(16'h0021);
    settle(12);
    check(lg_n == 0, "R4 disabled ignored", 64'(lg_n), 64'd0);
    cur_ssw = 32'h0000_0012;           // enabled, level 2
    pulse_irq(16'h0035);
    settle(12);
    check(lg_n == 0, "R4 level above ignored", 64'(lg_n), 64'd0);
  endtask

  task automatic t_equal_level;
    lg_n = 0;
    cur_ssw = 32'h0000_0013;           // enabled, level 3, supervisor
    mem[32'h9A8] = 32'hFFFF_FFFF;
    mem[32'h9AC] = 32'hCAFE_0000;
    pulse_irq(16'hFF35);               // R2 upper byte ignored
    expect_seq(0, 32'h9A8, 32'hCAFE_0000, 32'hFFFF_FFFF, "eq-level R4 R2");
  endtask

  task automatic t_wait_states;
    lg_n = 0; wait_n = 3; hold_err = 0;
    cur_ssw = 32'h0000_0110;
    pulse_irq(16'h0000);
    expect_seq(0, 32'h800, 32'h1234_5670, 32'h0000_0210, "wait R9");
    check(hold_err == 0, "R9 address held", 64'(hold_err), 64'd0);
    wait_n = 0;
  endtask

  task automatic t_trap_first;
    lg_n = 0;
    cur_ssw = 32'h0000_0000;
    mem[32'h3000] = 32'h0000_0055;
    mem[32'h3004] = 32'h0004_4440;
    @(negedge clk);
    trap_req = 1'b1; trap_addr = 32'h3000; irq_req = 1'b1; irq_vec = 16'h0000;
    @(negedge clk);
    trap_req = 1'b0; irq_req = 1'b0;
    expect_seq(0, 32'h3000, 32'h0004_4440, 32'h0000_0055, "trap R10");
    expect_seq(5, 32'h800, 32'h1234_5670, 32'h0000_0210, "after-trap R10");
  endtask

  task automatic t_while_busy;
    lg_n = 0;
    cur_ssw = 32'h0000_0011;           // enabled, level 1
    mem[32'h890] = 32'h0000_0300;
    mem[32'h894] = 32'h0008_8880;
    pulse_irq(16'h0000);
    settle(3);
    pulse_irq(16'h0012);               // arrives mid-sequence
    expect_seq(0, 32'h800, 32'h1234_5670, 32'h0000_0210, "busy-first R11");
    expect_seq(5, 32'h890, 32'h0008_8880, 32'h0000_0300, "busy-second R11");
  endtask

  task automatic t_drain_collision;
    lg_n = 0;
    cur_ssw = 32'h0000_0011;
    @(negedge clk); irq_req = 1'b1; irq_vec = 16'h0000;
    @(negedge clk); irq_vec = 16'h0012; // accepted at the edge the latch drains
    @(negedge clk); irq_req = 1'b0;
    expect_seq(0, 32'h800, 32'h1234_5670, 32'h0000_0210, "drain-first R11");
    expect_seq(5, 32'h890, 32'h0008_8880, 32'h0000_0300, "drain-second R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ssp = 32'h0001_0000;
    cur_pc = 32'h0000_4000;
    cur_psw = 32'h0000_000A;
    settle(3);
    t_reset;
    t_nmi_masked_state;
    t_masked;
    t_equal_level;
    t_wait_states;
    t_trap_first;
    t_while_busy;
    t_drain_collision;
    settle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule